// File: doc/BRIEF.md
# Selectable Code Tracking Error Discriminator

This block turns the integrated correlator results of one correlation interval into a signed code tracking error. For each interval it receives signed in-phase and quadrature values of four channels: the prompt replica, the early-minus-late difference replica, and the separate early and late replicas. A three-bit mode input chooses which discriminator law is applied to that interval. Each interval is marked by a one-cycle valid pulse, and the error appears with its own valid pulse two clock cycles later.

Five laws are offered. Two are dot products, one on the in-phase pair alone and one on both pairs. Two use sign decisions: the difference term is negated or passed according to the sign of the matching prompt term, so they need no multiplier. The fifth subtracts the late channel's power from the early channel's power. No law divides by the signal amplitude. The dot-product and power errors therefore grow with the square of the amplitude, and the sign-decision errors grow in proportion to it. The loop designer has to pick gains with this in mind. The full-precision result is clamped to a chosen output width. Correlation accumulation and loop filtering are done elsewhere.

Top module: `code_err_disc`

## Requirements
- R1: Mode code 0 (single-pair product): the error is `dif_i * prm_i`.
- R2: Mode code 1 (single-pair sign decision): the error is `dif_i` when `prm_i` is zero or positive, and `-dif_i` when it is negative.
- R3: Mode code 2 (two-pair product): the error is `dif_i * prm_i + dif_q * prm_q`.
- R4: Mode code 3 (two-pair sign decision): the error is `dif_i * sgn(prm_i) + dif_q * sgn(prm_q)`, where sgn gives +1 or -1.
- R5: Mode code 4 (power difference): the error is `erl_i^2 + erl_q^2 - lat_i^2 - lat_q^2`.
- R6: In both sign-decision modes a prompt value of exactly zero counts as positive, so the difference term passes through unchanged.
- R7: The full-precision result is clamped to the signed range of OUT_W bits. A value above 2^(OUT_W-1)-1 gives that maximum, and a value below -2^(OUT_W-1) gives that minimum.
- R8: `err_vld` is high exactly two rising edges after the edge that sampled `in_vld` high. Each input pulse gives exactly one output pulse, and back-to-back inputs give back-to-back outputs.
- R9: While `err_vld` is low, `err` keeps the last valid result.
- R10: Mode codes 5, 6 and 7 are reserved. A valid interval in a reserved mode gives an error of exactly zero with `err_vld` high.
- R11: While `rst_n` is low (asynchronous, active low), `err_vld` and `err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | One-cycle strobe marking a new set of correlator values |
| mode | input | 3 | Discriminator law select: 0..4 laws, 5..7 reserved |
| prm_i | input | IN_W | Prompt in-phase value, signed |
| prm_q | input | IN_W | Prompt quadrature value, signed |
| dif_i | input | IN_W | Early-minus-late in-phase value, signed |
| dif_q | input | IN_W | Early-minus-late quadrature value, signed |
| erl_i | input | IN_W | Early in-phase value, signed |
| erl_q | input | IN_W | Early quadrature value, signed |
| lat_i | input | IN_W | Late in-phase value, signed |
| lat_q | input | IN_W | Late quadrature value, signed |
| err_vld | output | 1 | Strobe marking a new error value |
| err | output | OUT_W | Clamped signed code tracking error |

## Verification
Every result is due two rising edges after the edge that captured its inputs. The bench drives inputs on the falling edge and records the expected strobe and value in a queue at that moment. On each later falling edge it compares the outputs with the entry recorded two falling edges earlier, so every compare falls exactly on the cycle the result is due. Cycles with no valid input are also recorded, which checks that the strobe stays low and the held value does not change in those gaps. The reference model computes each law with wide integers and clamps the result itself, and each compare names the requirement its case exercises.

// File: rtl/code_disc_pkg.sv
package code_disc_pkg;

    // Discriminator law codes carried on the mode input.
    localparam logic [2:0] DM_COH_DOT  = 3'd0;
    localparam logic [2:0] DM_COH_DD   = 3'd1;
    localparam logic [2:0] DM_NCOH_DOT = 3'd2;
    localparam logic [2:0] DM_NCOH_DD  = 3'd3;
    localparam logic [2:0] DM_PWR      = 3'd4;

    localparam int MODE_W = 3;

    // Number of correlator lanes (in-phase, quadrature).
    localparam int N_LANE = 2;

    function automatic logic mode_is_sign(input logic [2:0] m);
        return (m == DM_COH_DD) || (m == DM_NCOH_DD);
    endfunction

endpackage

// File: rtl/disc_sign_apply.sv
// Multiplies a value by the sign of a reference through conditional negation.
// A reference of zero counts as positive.
module disc_sign_apply #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] val_i,
    input  logic signed [W-1:0] ref_i,
    output logic signed [W:0]   res_o
);
    localparam int RW = W + 1;

    logic signed [RW-1:0] val_ext;

    assign val_ext = RW'(val_i);

    always_comb begin
        if (ref_i[W-1]) begin
            res_o = -val_ext;
        end else begin
            res_o = val_ext;
        end
    end
endmodule

// File: rtl/disc_term_stage.sv
// Forms the two partial terms of the selected law. The top sums them one
// register stage later.
module disc_term_stage
    import code_disc_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int SUM_W = 2 * IN_W + 1
) (
    input  logic [MODE_W-1:0]   mode_i,
    input  logic signed [IN_W-1:0] prm_i,
    input  logic signed [IN_W-1:0] prm_q,
    input  logic signed [IN_W-1:0] dif_i,
    input  logic signed [IN_W-1:0] dif_q,
    input  logic signed [IN_W-1:0] erl_i,
    input  logic signed [IN_W-1:0] erl_q,
    input  logic signed [IN_W-1:0] lat_i,
    input  logic signed [IN_W-1:0] lat_q,
    output logic signed [SUM_W-1:0] term_a_o,
    output logic signed [SUM_W-1:0] term_b_o
);
    localparam int PROD_W = 2 * IN_W;
    localparam int DD_W   = IN_W + 1;

    logic signed [IN_W-1:0]   prm_l [N_LANE];
    logic signed [IN_W-1:0]   dif_l [N_LANE];
    logic signed [IN_W-1:0]   erl_l [N_LANE];
    logic signed [IN_W-1:0]   lat_l [N_LANE];
    logic signed [PROD_W-1:0] dot_l [N_LANE];
    logic signed [PROD_W-1:0] esq_l [N_LANE];
    logic signed [PROD_W-1:0] lsq_l [N_LANE];
    logic signed [DD_W-1:0]   dd_l  [N_LANE];

    logic signed [SUM_W-1:0] esum;
    logic signed [SUM_W-1:0] lsum;

    assign prm_l[0] = prm_i;
    assign prm_l[1] = prm_q;
    assign dif_l[0] = dif_i;
    assign dif_l[1] = dif_q;
    assign erl_l[0] = erl_i;
    assign erl_l[1] = erl_q;
    assign lat_l[0] = lat_i;
    assign lat_l[1] = lat_q;

    for (genvar k = 0; k < N_LANE; k++) begin : g_lane
        disc_sign_apply #(
            .W(IN_W)
        ) u_sgn (
            .val_i(dif_l[k]),
            .ref_i(prm_l[k]),
            .res_o(dd_l[k])
        );

        assign dot_l[k] = PROD_W'(dif_l[k]) * PROD_W'(prm_l[k]);
        assign esq_l[k] = PROD_W'(erl_l[k]) * PROD_W'(erl_l[k]);
        assign lsq_l[k] = PROD_W'(lat_l[k]) * PROD_W'(lat_l[k]);
    end

    assign esum = SUM_W'(esq_l[0]) + SUM_W'(esq_l[1]);
    assign lsum = SUM_W'(lsq_l[0]) + SUM_W'(lsq_l[1]);

    always_comb begin
        term_a_o = '0;
        term_b_o = '0;
        unique case (mode_i)
            DM_COH_DOT: begin
                term_a_o = SUM_W'(dot_l[0]);
            end
            DM_COH_DD: begin
                term_a_o = SUM_W'(dd_l[0]);
            end
            DM_NCOH_DOT: begin
                term_a_o = SUM_W'(dot_l[0]);
                term_b_o = SUM_W'(dot_l[1]);
            end
            DM_NCOH_DD: begin
                term_a_o = SUM_W'(dd_l[0]);
                term_b_o = SUM_W'(dd_l[1]);
            end
            DM_PWR: begin
                term_a_o = esum;
                term_b_o = -lsum;
            end
            default: begin
                term_a_o = '0;
                term_b_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/disc_sat.sv
// Clamps a wide signed value to OUT_W bits, or sign-extends it when it
// already fits.
module disc_sat #(
    parameter int IN_WID = 34,
    parameter int OUT_W  = 20
) (
    input  logic signed [IN_WID-1:0] val_i,
    output logic signed [OUT_W-1:0]  val_o
);
    if (OUT_W >= IN_WID) begin : g_extend
        assign val_o = OUT_W'(val_i);
    end else begin : g_clamp
        localparam int TOP_N = IN_WID - OUT_W + 1;
        localparam logic signed [OUT_W-1:0] MAX_V = {1'b0, {(OUT_W-1){1'b1}}};
        localparam logic signed [OUT_W-1:0] MIN_V = {1'b1, {(OUT_W-1){1'b0}}};

        logic [TOP_N-1:0] top_bits;
        logic             fits;

        assign top_bits = val_i[IN_WID-1:OUT_W-1];
        assign fits     = (top_bits == '0) || (top_bits == '1);

        always_comb begin
            if (fits) begin
                val_o = val_i[OUT_W-1:0];
            end else if (val_i[IN_WID-1]) begin
                val_o = MIN_V;
            end else begin
                val_o = MAX_V;
            end
        end
    end
endmodule

// File: rtl/code_err_disc.sv
// Selectable code tracking error discriminator, two register stages.
module code_err_disc
    import code_disc_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic [2:0]               mode,
    input  logic signed [IN_W-1:0]   prm_i,
    input  logic signed [IN_W-1:0]   prm_q,
    input  logic signed [IN_W-1:0]   dif_i,
    input  logic signed [IN_W-1:0]   dif_q,
    input  logic signed [IN_W-1:0]   erl_i,
    input  logic signed [IN_W-1:0]   erl_q,
    input  logic signed [IN_W-1:0]   lat_i,
    input  logic signed [IN_W-1:0]   lat_q,
    output logic                     err_vld,
    output logic signed [OUT_W-1:0]  err
);
    localparam int SUM_W = 2 * IN_W + 1;
    localparam int TOT_W = SUM_W + 1;

    logic signed [SUM_W-1:0] term_a;
    logic signed [SUM_W-1:0] term_b;
    logic signed [SUM_W-1:0] s1_a;
    logic signed [SUM_W-1:0] s1_b;
    logic                    s1_vld;
    logic signed [TOT_W-1:0] s2_sum;
    logic signed [OUT_W-1:0] s2_sat;

    disc_term_stage #(
        .IN_W (IN_W),
        .SUM_W(SUM_W)
    ) u_terms (
        .mode_i  (mode),
        .prm_i   (prm_i),
        .prm_q   (prm_q),
        .dif_i   (dif_i),
        .dif_q   (dif_q),
        .erl_i   (erl_i),
        .erl_q   (erl_q),
        .lat_i   (lat_i),
        .lat_q   (lat_q),
        .term_a_o(term_a),
        .term_b_o(term_b)
    );

    // Stage 1: capture the partial terms.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_a   <= '0;
            s1_b   <= '0;
        end else begin
            s1_vld <= in_vld;
            if (in_vld) begin
                s1_a <= term_a;
                s1_b <= term_b;
            end
        end
    end

    assign s2_sum = TOT_W'(s1_a) + TOT_W'(s1_b);

    disc_sat #(
        .IN_WID(TOT_W),
        .OUT_W (OUT_W)
    ) u_sat (
        .val_i(s2_sum),
        .val_o(s2_sat)
    );

    // Stage 2: clamped result, held between valid intervals.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_vld <= 1'b0;
            err     <= '0;
        end else begin
            err_vld <= s1_vld;
            if (s1_vld) begin
                err <= s2_sat;
            end
        end
    end
endmodule

// File: rtl/code_disc_chk.sv
module code_disc_chk
    import code_disc_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 20
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_vld,
    input logic [2:0]              mode,
    input logic signed [IN_W-1:0]  prm_i,
    input logic signed [IN_W-1:0]  erl_i,
    input logic signed [IN_W-1:0]  erl_q,
    input logic signed [IN_W-1:0]  lat_i,
    input logic signed [IN_W-1:0]  lat_q,
    input logic                    err_vld,
    input logic signed [OUT_W-1:0] err
);
    localparam longint DD_LIM = longint'(1) << (IN_W - 1);

    logic [1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= 2'd0;
        end else if (cyc != 2'd2) begin
            cyc <= cyc + 2'd1;
        end
    end

    // R8: output strobe follows the input strobe by two edges.
    p_vld_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd2) |-> (err_vld == $past(in_vld, 2)));

    // R9: value unchanged when no new result arrives.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd2 && !err_vld) |-> $stable(err));

    // R10: reserved codes give zero.
    p_resv_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd2 && err_vld && $past(in_vld, 2) && $past(mode, 2) > DM_PWR)
        |-> (err == '0));

    // R2: sign-decision single-pair result bounded by input magnitude.
    p_dd_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd2 && err_vld && $past(in_vld, 2) && $past(mode, 2) == DM_COH_DD)
        |-> (longint'(err) <= DD_LIM && longint'(err) >= -DD_LIM));

    // R5: equal early and late channels cancel.
    p_pwr_sym_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd2 && err_vld && $past(in_vld, 2) && $past(mode, 2) == DM_PWR
         && $past(erl_i, 2) == $past(lat_i, 2) && $past(erl_q, 2) == $past(lat_q, 2))
        |-> (err == '0));

    // R1: zero prompt gives zero product.
    p_dot_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd2 && err_vld && $past(in_vld, 2) && $past(mode, 2) == DM_COH_DOT
         && $past(prm_i, 2) == '0)
        |-> (err == '0));

    // R11: reset clears outputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_r11: assert (err_vld == 1'b0 && err == '0);
        end
    end
endmodule

bind code_err_disc code_disc_chk #(
    .IN_W (IN_W),
    .OUT_W(OUT_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (in_vld),
    .mode   (mode),
    .prm_i  (prm_i),
    .erl_i  (erl_i),
    .erl_q  (erl_q),
    .lat_i  (lat_i),
    .lat_q  (lat_q),
    .err_vld(err_vld),
    .err    (err)
);

// File: tb/code_err_disc_tb.sv
module code_err_disc_tb_top;
    localparam int    IN_W    = 16;
    localparam int    OUT_W   = 20;
    localparam time   CLK_PER = 10ns;
    localparam longint OMAX   = (longint'(1) << (OUT_W - 1)) - 1;
    localparam longint OMIN   = -(longint'(1) << (OUT_W - 1));

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_vld = 1'b0;
    logic [2:0]              mode = '0;
    logic signed [IN_W-1:0]  prm_i = '0, prm_q = '0, dif_i = '0, dif_q = '0;
    logic signed [IN_W-1:0]  erl_i = '0, erl_q = '0, lat_i = '0, lat_q = '0;
    logic                    err_vld;
    logic signed [OUT_W-1:0] err;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        bit     v;
        longint e;
        int     tag;
    } exp_t;

    exp_t   exp_q[$];
    longint last_e = 0;

    always #(CLK_PER / 2) clk = ~clk;

    code_err_disc #(
        .IN_W (IN_W),
        .OUT_W(OUT_W)
    ) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (in_vld),
        .mode   (mode),
        .prm_i  (prm_i),
        .prm_q  (prm_q),
        .dif_i  (dif_i),
        .dif_q  (dif_q),
        .erl_i  (erl_i),
        .erl_q  (erl_q),
        .lat_i  (lat_i),
        .lat_q  (lat_q),
        .err_vld(err_vld),
        .err    (err)
    );

    function automatic longint sgn(input longint p);
        return (p >= 0) ? 1 : -1;
    endfunction

    function automatic longint law(input int m, input longint pi, input longint pq,
                                   input longint di, input longint dq, input longint ei,
                                   input longint eq, input longint li, input longint lq);
        case (m)
            0: return di * pi;
            1: return di * sgn(pi);
            2: return di * pi + dq * pq;
            3: return di * sgn(pi) + dq * sgn(pq);
            4: return ei * ei + eq * eq - li * li - lq * lq;
            default: return 0;
        endcase
    endfunction

    function automatic longint clamp(input longint x);
        if (x > OMAX) return OMAX;
        if (x < OMIN) return OMIN;
        return x;
    endfunction

    function automatic string tag_s(input int t);
        return $sformatf("R%0d", t);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic compare();
        exp_t x;
        if (exp_q.size() == 2) begin
            x = exp_q.pop_front();
            chk(err_vld == x.v, "R8", longint'(err_vld), longint'(x.v));
            chk(longint'(err) == x.e, x.v ? tag_s(x.tag) : "R9", longint'(err), x.e);
        end
    endtask

    task automatic step(input bit v, input int m, input int pi, input int pq,
                        input int di, input int dq, input int ei, input int eq,
                        input int li, input int lq);
        exp_t x;
        longint raw;
        @(negedge clk);
        compare();
        in_vld = v;
        mode   = 3'(m);
        prm_i  = IN_W'(pi);
        prm_q  = IN_W'(pq);
        dif_i  = IN_W'(di);
        dif_q  = IN_W'(dq);
        erl_i  = IN_W'(ei);
        erl_q  = IN_W'(eq);
        lat_i  = IN_W'(li);
        lat_q  = IN_W'(lq);
        raw = law(m, longint'(prm_i), longint'(prm_q), longint'(dif_i), longint'(dif_q),
                  longint'(erl_i), longint'(erl_q), longint'(lat_i), longint'(lat_q));
        if (v) last_e = clamp(raw);
        x.v = v;
        x.e = last_e;
        if (m > 4)                          x.tag = 10;
        else if (clamp(raw) != raw)         x.tag = 7;
        else if ((m == 1 || m == 3) && (prm_i == 0 || (m == 3 && prm_q == 0))) x.tag = 6;
        else                                x.tag = m + 1;
        exp_q.push_back(x);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(err_vld == 1'b0, "R11", longint'(err_vld), 0);
        chk(err == '0, "R11", longint'(err), 0);
        rst_n = 1'b1;

        // R1 single-pair product
        step(1, 0, 7, 99, -5, 99, 0, 0, 0, 0);
        step(1, 0, -300, 0, -200, 0, 0, 0, 0, 0);
        // R2 sign decision, negative and positive prompt
        step(1, 1, -4, 0, 123, 0, 0, 0, 0, 0);
        step(1, 1, 9, 0, -77, 0, 0, 0, 0, 0);
        // R6 zero prompt counts as positive
        step(1, 1, 0, 0, -55, 0, 0, 0, 0, 0);
        step(1, 3, 0, 0, 40, -60, 0, 0, 0, 0);
        // R2 extreme: negating the most negative difference
        step(1, 1, -1, 0, -32768, 0, 0, 0, 0, 0);
        // R3 two-pair product
        step(1, 2, 10, -20, 30, 40, 0, 0, 0, 0);
        // R4 two-pair sign decision
        step(1, 3, -1, 5, 100, -250, 0, 0, 0, 0);
        // R5 power difference
        step(1, 4, 0, 0, 0, 0, 30, -40, 20, 10);
        step(1, 4, 0, 0, 0, 0, 5, 5, -5, 5);
        // R9 gap: held value
        step(0, 0, 1000, 0, 1000, 0, 0, 0, 0, 0);
        step(0, 4, 0, 0, 0, 0, 900, 0, 0, 0);
        // R7 clamp high and low
        step(1, 4, 0, 0, 0, 0, -32768, -32768, 0, 0);
        step(1, 4, 0, 0, 0, 0, 0, 0, 32767, 1000);
        step(1, 2, 32767, 32767, 32767, 32767, 0, 0, 0, 0);
        step(1, 0, -32768, 0, 32767, 0, 0, 0, 0, 0);
        // R10 reserved codes
        step(1, 5, 11, 12, 13, 14, 15, 16, 17, 18);
        step(1, 7, 11, 12, 13, 14, 15, 16, 17, 18);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 6, 1, 1, 1, 1, 1, 1, 1, 1);

        // mixed random traffic, small and full-scale values
        for (int n = 0; n < 3000; n++) begin
            int vals[8];
            bit full;
            full = ($urandom % 3) == 0;
            for (int k = 0; k < 8; k++) begin
                logic [31:0] r;
                logic signed [9:0] sm;
                r  = $urandom;
                sm = r[9:0];
                vals[k] = full ? int'($signed(r[15:0])) : int'(sm);
            end
            step(($urandom % 4) != 0, int'($urandom % 8), vals[0], vals[1], vals[2],
                 vals[3], vals[4], vals[5], vals[6], vals[7]);
        end

        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule